// File: doc/BRIEF.md
# Supply Reset Sequencing Controller

This block merges every digital reset request that comes from the supply supervisors and from the external master-clear pin into one synchronous device reset. The power-on flag, the accurate and the low-power brown-out comparator outputs, the reference status flags, the deep-sleep indicator and the raw pin all arrive as plain logic levels. The analog circuits that produce them are outside the block. The controller decides when each brown-out monitor may be armed. It rejects short glitches on the pin. It keeps the device in reset for a fixed hold time after the last request clears. It also records which source caused each reset in a sticky cause register that software clears by writing ones.

The power-on flag also acts as the block's own synchronous reset. While it is high, every register returns to its initial state, and the cause register shows only the power-on bit. The glitch filter length is derived from the clock frequency and the minimum pulse width, which are both parameters. With the defaults (100 MHz, 400 ns), the filter needs 40 cycles.

Top module: `supply_reset_seq`

## Requirements
- R1: While `por_i` is high, `dev_rst_o` is 1, `cause_o` reads 4'b0001, both monitor enables read 0 and the stored low-power monitor enable is cleared. `dev_rst_o` stays 1 through the hold time after `por_i` falls.
- R2: `bor_mon_en_o` is 1 exactly when `por_i` is 0, `bg_en_i` and `bg_rdy_i` are both 1 and `deep_sleep_i` is 0. While it is 0, `bor_trip_i` causes no reset.
- R3: A write on `lpbor_en_wr_i` loads `lpbor_en_wdata_i` into the stored low-power monitor enable only when `lpbor_cfg_i` is 1. A write while `lpbor_cfg_i` is 0 leaves the stored value unchanged.
- R4: `lpbor_mon_en_o` is 1 only while the stored enable is 1 and `deep_sleep_i` is 1. `lpbor_trip_i` causes a reset only then.
- R5: `mclr_n_i` passes through a two-flop synchronizer. A low level lasting at least the filter length (40 cycles at the defaults) raises a reset request. A single low pulse shorter than that raises none.
- R6: Any high sample on the synchronized pin restarts the low-level count, so two short low pulses separated by one high cycle raise no request.
- R7: `dev_rst_o` is registered. It is 1 in the cycle after any active source. After the last source goes inactive it stays 1 for 16 more cycles: from the clock edge at which the last active source is seen, it remains 1 for 17 edges.
- R8: Cause bits are sticky and set on the matching event: bit 0 power-on, bit 1 accurate brown-out, bit 2 low-power brown-out, bit 3 master-clear.
- R9: A 1 in bit n of `cause_clr_i` clears cause bit n and leaves the other bits alone. A new event on the same bit in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on reset flag, active high; also the block's synchronous reset |
| bg_en_i | input | 1 | Reference voltage enabled |
| bg_rdy_i | input | 1 | Reference voltage ready |
| deep_sleep_i | input | 1 | Device is in deep sleep |
| lpbor_cfg_i | input | 1 | Configuration bit that permits arming the low-power monitor |
| lpbor_en_wr_i | input | 1 | Write strobe for the low-power monitor enable |
| lpbor_en_wdata_i | input | 1 | Write data for the low-power monitor enable |
| bor_trip_i | input | 1 | Accurate brown-out comparator, 1 = supply below threshold |
| lpbor_trip_i | input | 1 | Low-power brown-out comparator, 1 = supply below threshold |
| mclr_n_i | input | 1 | Raw master-clear pin, active low, asynchronous |
| cause_clr_i | input | 4 | Write-one-to-clear strobes for the cause bits |
| dev_rst_o | output | 1 | Synchronous device reset, active high |
| bor_mon_en_o | output | 1 | Arms the accurate brown-out monitor |
| lpbor_mon_en_o | output | 1 | Arms the low-power brown-out monitor |
| cause_o | output | 4 | Sticky reset cause bits |

## Verification
The pin filter is driven with single low pulses of 1, 5, 39, 40 and 60 cycles. These show where the filter accepts a pulse, with the 39 and 40 cycle cases sitting on either side of the threshold. A split pulse of 30 low, 1 high and 30 low confirms that the count restarts on a high sample rather than adding up. The brown-out paths are tried with each gating input missing in turn (reference not ready, deep sleep on or off, configuration bit cleared) and then with all gates open. This separates a trip that is correctly blocked from one that should reset the device. The hold time is measured by counting reset cycles after power-on ends. Cause clears are tried on one bit alone and on a bit that sees a new event in the same cycle.

// File: rtl/srs_pkg.sv
package srs_pkg;

    // Cause record; por sits at bit 0 and mclr at bit 3.
    typedef struct packed {
        logic mclr;
        logic lpbor;
        logic bor;
        logic por;
    } cause_t;

    localparam int CAUSE_W = 4;

    localparam cause_t CAUSE_AFTER_POR = '{mclr: 1'b0, lpbor: 1'b0, bor: 1'b0, por: 1'b1};

    // Cycles needed to cover a pulse width, rounded up.
    function automatic int ns_to_cycles(input int clk_mhz, input int width_ns);
        return (clk_mhz * width_ns + 999) / 1000;
    endfunction

endpackage

// File: rtl/srs_pin_filter.sv
module srs_pin_filter #(
    parameter int FILT_CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    output logic req_o
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FILT_CYCLES);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] low_cnt_q;
    logic             pin_low;

    assign pin_low = ~sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= 2'b11;
            low_cnt_q <= '0;
        end else begin
            sync_q <= {sync_q[0], pin_n_i};
            if (!pin_low)
                low_cnt_q <= '0;
            else if (low_cnt_q != CNT_FULL)
                low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign req_o = (low_cnt_q == CNT_FULL);

    AST_REQ_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        req_o |-> $past(pin_low)); // R5

    AST_HIGH_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        !pin_low |=> !req_o); // R6

endmodule

// File: rtl/srs_monitor_gate.sv
module srs_monitor_gate (
    input  logic clk,
    input  logic rst,
    input  logic bg_en_i,
    input  logic bg_rdy_i,
    input  logic deep_sleep_i,
    input  logic cfg_i,
    input  logic wr_i,
    input  logic wdata_i,
    input  logic bor_trip_i,
    input  logic lpbor_trip_i,
    output logic bor_en_o,
    output logic lpbor_en_o,
    output logic bor_ev_o,
    output logic lpbor_ev_o
);
    logic lp_arm_q;

    always_ff @(posedge clk) begin
        if (rst)
            lp_arm_q <= 1'b0;
        else if (wr_i && cfg_i)
            lp_arm_q <= wdata_i;
    end

    assign bor_en_o   = ~rst & bg_en_i & bg_rdy_i & ~deep_sleep_i;
    assign lpbor_en_o = ~rst & lp_arm_q & deep_sleep_i;
    assign bor_ev_o   = bor_en_o & bor_trip_i;
    assign lpbor_ev_o = lpbor_en_o & lpbor_trip_i;

    AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !cfg_i) |=> $stable(lp_arm_q)); // R3

    AST_LP_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        lpbor_ev_o |-> deep_sleep_i); // R4

endmodule

// File: rtl/srs_cause_reg.sv
module srs_cause_reg
    import srs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t ev_i,
    input  cause_t clr_i,
    output cause_t cause_o
);
    cause_t cause_q;

    always_ff @(posedge clk) begin
        if (rst)
            cause_q <= CAUSE_AFTER_POR;
        else
            cause_q <= (cause_q & ~clr_i) | ev_i;
    end

    assign cause_o = cause_q;

    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (rst)
        ev_i.mclr |=> cause_q.mclr); // R8

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (clr_i.bor && !ev_i.bor) |=> !cause_q.bor); // R9

endmodule

// File: rtl/srs_stretch.sv
module srs_stretch #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic src_i,
    output logic rst_o
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYCLES);

    logic [HW-1:0] hold_q;
    logic          rst_q;

    always_ff @(posedge clk) begin
        if (rst || src_i) begin
            hold_q <= HOLD_LOAD;
            rst_q  <= 1'b1;
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
            rst_q  <= 1'b1;
        end else begin
            rst_q  <= 1'b0;
        end
    end

    assign rst_o = rst_q;

    AST_POR_EXIT_HELD: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rst_q); // R1

    AST_SOURCE_ASSERTS: assert property (@(posedge clk) disable iff (rst)
        src_i |=> (rst_q && hold_q == HOLD_LOAD)); // R7

endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
    import srs_pkg::*;
#(
    parameter int CLK_MHZ      = 100,
    parameter int MIN_PULSE_NS = 400,
    parameter int HOLD_CYCLES  = 16
) (
    input  logic               clk,
    input  logic               por_i,
    input  logic               bg_en_i,
    input  logic               bg_rdy_i,
    input  logic               deep_sleep_i,
    input  logic               lpbor_cfg_i,
    input  logic               lpbor_en_wr_i,
    input  logic               lpbor_en_wdata_i,
    input  logic               bor_trip_i,
    input  logic               lpbor_trip_i,
    input  logic               mclr_n_i,
    input  logic [CAUSE_W-1:0] cause_clr_i,
    output logic               dev_rst_o,
    output logic               bor_mon_en_o,
    output logic               lpbor_mon_en_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int FILT_CYCLES = ns_to_cycles(CLK_MHZ, MIN_PULSE_NS);

    logic   mclr_req;
    logic   bor_ev;
    logic   lpbor_ev;
    logic   any_src;
    cause_t events;
    cause_t clears;
    cause_t cause_q;

    srs_pin_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filter (
        .clk     (clk),
        .rst     (por_i),
        .pin_n_i (mclr_n_i),
        .req_o   (mclr_req)
    );

    srs_monitor_gate u_gate (
        .clk          (clk),
        .rst          (por_i),
        .bg_en_i      (bg_en_i),
        .bg_rdy_i     (bg_rdy_i),
        .deep_sleep_i (deep_sleep_i),
        .cfg_i        (lpbor_cfg_i),
        .wr_i         (lpbor_en_wr_i),
        .wdata_i      (lpbor_en_wdata_i),
        .bor_trip_i   (bor_trip_i),
        .lpbor_trip_i (lpbor_trip_i),
        .bor_en_o     (bor_mon_en_o),
        .lpbor_en_o   (lpbor_mon_en_o),
        .bor_ev_o     (bor_ev),
        .lpbor_ev_o   (lpbor_ev)
    );

    always_comb begin
        events       = '0;
        events.por   = por_i;
        events.bor   = bor_ev;
        events.lpbor = lpbor_ev;
        events.mclr  = mclr_req;
    end

    assign clears  = cause_t'(cause_clr_i);
    assign any_src = |events;

    srs_cause_reg u_cause (
        .clk     (clk),
        .rst     (por_i),
        .ev_i    (events),
        .clr_i   (clears),
        .cause_o (cause_q)
    );

    srs_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_stretch (
        .clk   (clk),
        .rst   (por_i),
        .src_i (any_src),
        .rst_o (dev_rst_o)
    );

    assign cause_o = cause_q;

    AST_BOR_NEEDS_REF: assert property (@(posedge clk) disable iff (por_i)
        bor_ev |-> (bg_rdy_i && bg_en_i && !deep_sleep_i)); // R2

    AST_TRIP_MARKS_CAUSE: assert property (@(posedge clk) disable iff (por_i)
        bor_ev |=> (cause_q.bor && dev_rst_o)); // R8

endmodule

// File: tb/supply_reset_seq_test.sv
module supply_reset_seq_test;

    logic       clk = 1'b0;
    logic       por_i, bg_en_i, bg_rdy_i, deep_sleep_i, lpbor_cfg_i;
    logic       lpbor_en_wr_i, lpbor_en_wdata_i, bor_trip_i, lpbor_trip_i, mclr_n_i;
    logic [3:0] cause_clr_i;
    logic       dev_rst_o, bor_mon_en_o, lpbor_mon_en_o;
    logic [3:0] cause_o;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 1'b0;

    always #5 clk = ~clk;

    supply_reset_seq uut (
        .clk              (clk),
        .por_i            (por_i),
        .bg_en_i          (bg_en_i),
        .bg_rdy_i         (bg_rdy_i),
        .deep_sleep_i     (deep_sleep_i),
        .lpbor_cfg_i      (lpbor_cfg_i),
        .lpbor_en_wr_i    (lpbor_en_wr_i),
        .lpbor_en_wdata_i (lpbor_en_wdata_i),
        .bor_trip_i       (bor_trip_i),
        .lpbor_trip_i     (lpbor_trip_i),
        .mclr_n_i         (mclr_n_i),
        .cause_clr_i      (cause_clr_i),
        .dev_rst_o        (dev_rst_o),
        .bor_mon_en_o     (bor_mon_en_o),
        .lpbor_mon_en_o   (lpbor_mon_en_o),
        .cause_o          (cause_o)
    );

    // Pulse length in cycles, and whether a reset is expected (R5).
    localparam int NVEC = 5;
    localparam int VEC_LEN [NVEC] = '{1, 5, 39, 40, 60};
    localparam bit VEC_RST [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    task automatic wait_idle_and_clear();
        while (dev_rst_o) @(negedge clk);
        cause_clr_i = 4'hF;
        @(negedge clk);
        cause_clr_i = 4'h0;
        @(negedge clk);
    endtask

    // Low pulse of len cycles; returns whether reset was seen soon after.
    task automatic pin_pulse(input int len, output bit saw);
        saw = 1'b0;
        mclr_n_i = 1'b0;
        repeat (len) @(negedge clk);
        mclr_n_i = 1'b1;
        repeat (8) begin
            @(negedge clk);
            saw |= dev_rst_o;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        bit saw, saw2;
        por_i = 1'b1; bg_en_i = 1'b1; bg_rdy_i = 1'b1; deep_sleep_i = 1'b0;
        lpbor_cfg_i = 1'b1; lpbor_en_wr_i = 1'b0; lpbor_en_wdata_i = 1'b0;
        bor_trip_i = 1'b0; lpbor_trip_i = 1'b0; mclr_n_i = 1'b1; cause_clr_i = 4'h0;
        repeat (5) @(negedge clk);

        // R1: state during power-on reset
        chk("R1 dev_rst during por", dev_rst_o, 1);
        chk("R1 cause during por", cause_o, 4'b0001);
        chk("R1 bor_mon_en during por", bor_mon_en_o, 0);
        chk("R1 lpbor_mon_en during por", lpbor_mon_en_o, 0);

        // R7: hold time after power-on ends
        por_i = 1'b0;
        n = 0;
        while (dev_rst_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R7 reset hold after por", n, 17);
        chk("R2 bor_mon_en with reference ready", bor_mon_en_o, 1);
        chk("R8 por cause kept after release", cause_o, 4'b0001);
        wait_idle_and_clear();
        chk("R9 cause cleared by write", cause_o, 0);

        // R5: table of single pulses
        for (int i = 0; i < NVEC; i++) begin
            pin_pulse(VEC_LEN[i], saw);
            chk($sformatf("R5 pulse of %0d cycles", VEC_LEN[i]), saw, VEC_RST[i]);
            chk($sformatf("R8 mclr cause after %0d cycles", VEC_LEN[i]), cause_o[3], VEC_RST[i]);
            wait_idle_and_clear();
        end

        // R6: split pulse 30 low / 1 high / 30 low
        mclr_n_i = 1'b0;
        repeat (30) @(negedge clk);
        mclr_n_i = 1'b1;
        @(negedge clk);
        pin_pulse(30, saw);
        chk("R6 split pulse rejected", saw, 0);
        chk("R6 no mclr cause", cause_o[3], 0);

        // R2: accurate monitor gated by reference ready
        bg_rdy_i = 1'b0;
        @(negedge clk);
        chk("R2 bor_mon_en off without ready", bor_mon_en_o, 0);
        bor_trip_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 trip ignored while disabled", dev_rst_o, 0);
        chk("R2 no bor cause while disabled", cause_o[1], 0);
        bor_trip_i = 1'b0;
        bg_rdy_i = 1'b1;
        @(negedge clk);
        bor_trip_i = 1'b1;
        @(negedge clk);
        bor_trip_i = 1'b0;
        chk("R7 reset one cycle after trip", dev_rst_o, 1);
        chk("R8 bor cause set", cause_o, 4'b0010);
        wait_idle_and_clear();
        deep_sleep_i = 1'b1;
        @(negedge clk);
        chk("R2 bor_mon_en off in deep sleep", bor_mon_en_o, 0);

        // R3: enable write while the configuration bit is clear
        lpbor_cfg_i = 1'b0;
        lpbor_en_wr_i = 1'b1; lpbor_en_wdata_i = 1'b1;
        @(negedge clk);
        lpbor_en_wr_i = 1'b0;
        chk("R3 locked write ignored", lpbor_mon_en_o, 0);
        lpbor_cfg_i = 1'b1;
        lpbor_en_wr_i = 1'b1;
        @(negedge clk);
        lpbor_en_wr_i = 1'b0;
        chk("R3 permitted write arms monitor", lpbor_mon_en_o, 1);

        // R4: only active in deep sleep
        deep_sleep_i = 1'b0;
        lpbor_trip_i = 1'b1;
        @(negedge clk);
        chk("R4 lpbor_mon_en off when awake", lpbor_mon_en_o, 0);
        chk("R4 trip ignored when awake", dev_rst_o, 0);
        lpbor_trip_i = 1'b0;
        deep_sleep_i = 1'b1;
        @(negedge clk);
        lpbor_trip_i = 1'b1;
        @(negedge clk);
        lpbor_trip_i = 1'b0;
        chk("R4 trip resets in deep sleep", dev_rst_o, 1);
        chk("R8 lpbor cause set", cause_o, 4'b0100);

        // R3: clearing the bit blocks a disarm write as well
        lpbor_cfg_i = 1'b0;
        lpbor_en_wr_i = 1'b1; lpbor_en_wdata_i = 1'b0;
        @(negedge clk);
        lpbor_en_wr_i = 1'b0;
        chk("R3 locked disarm ignored", lpbor_mon_en_o, 1);
        wait_idle_and_clear();

        // R9: single-bit clear and set-over-clear
        deep_sleep_i = 1'b0;
        @(negedge clk);
        bor_trip_i = 1'b1;
        @(negedge clk);
        bor_trip_i = 1'b0;
        pin_pulse(45, saw2);
        chk("R5 long pulse accepted", saw2, 1);
        chk("R8 two causes recorded", cause_o, 4'b1010);
        cause_clr_i = 4'b1000;
        @(negedge clk);
        cause_clr_i = 4'b0000;
        chk("R9 one bit cleared, other kept", cause_o, 4'b0010);
        bor_trip_i = 1'b1;
        cause_clr_i = 4'b0010;
        @(negedge clk);
        bor_trip_i = 1'b0;
        cause_clr_i = 4'b0000;
        chk("R9 new event wins over clear", cause_o[1], 1);

        // R1: power-on in mid operation
        deep_sleep_i = 1'b1;
        por_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 cause after second por", cause_o, 4'b0001);
        chk("R1 lpbor enable cleared by por", lpbor_mon_en_o, 0);
        chk("R1 dev_rst during second por", dev_rst_o, 1);
        por_i = 1'b0;
        @(negedge clk);
        chk("R1 stored enable stays cleared", lpbor_mon_en_o, 0);
        chk("R1 reset held after por", dev_rst_o, 1);

        finish_run();
    end

endmodule